// File: doc/BRIEF.md
# Alarm Match and Interrupt Flag Unit

This unit sits beside the timekeeping counters of a real-time clock. It holds three alarm bytes for seconds, minutes and hours. On each update strobe, after the time fields have advanced, it compares the alarm bytes with the current time. Three kinds of event are collected into sticky flags: the periodic tick from the divider, the alarm match, and the end of an update cycle.

A control byte holds one enable per event. A summary bit and the `irq_o` line are high while any flag is set and its enable is 1. Software reads the flag byte through a small register port. A read returns the current flags and clears them on the next edge, which drops the interrupt. A read-only status byte shows whether the backup supply is good. Register reads are combinational from the address, so data is valid in the same cycle as the read strobe.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, the alarm bytes, the control byte and all flags are 0, `irq_o` is 0, and reads of addresses 0 to 4 return 0.
- R2: Register addresses are: 0 seconds alarm, 1 minutes alarm, 2 hours alarm, 3 control, 4 flags, 5 supply status. A write with `reg_we_i` to addresses 0 to 3 is stored at the clock edge and reads back in full. Addresses 6 and 7 read 0.
- R3: A cycle with `update_done_i` high sets flag bit 4. A cycle with `periodic_i` high sets flag bit 6.
- R4: Flag bit 5 (alarm) is set at the edge ending a cycle with `update_done_i` high, but only when `sec_i`, `min_i` and `hour_i` all equal their alarm bytes. A mismatch in any one field, or an exact match without the update strobe, leaves bit 5 unchanged.
- R5: Flags are set by their events whatever the enables are, and they stay set until a clearing read.
- R6: Control bits 6, 5 and 4 enable the periodic, alarm and update-ended flags. Flag bit 7 reads as 1 exactly when a flag in bits 6..4 and its enable are both 1. `irq_o` equals that bit.
- R7: A cycle with `reg_re_i` high at address 4 returns the flags, and all flag bits are 0 after the edge. Addressing the flags with `reg_re_i` low does not clear them.
- R8: An event in the same cycle as a clearing read is kept: its flag is set after the edge.
- R9: Bit 7 of the status byte (address 5) follows `batt_ok_i` (1 means the supply is good). Bits 3..0 of the flag byte and bits 6..0 of the status byte read 0.
- R10: Writes to addresses 4 to 7 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| periodic_i | input | 1 | Periodic tick strobe from the divider |
| update_done_i | input | 1 | Strobe: time fields have just advanced |
| sec_i | input | 8 | Current seconds field |
| min_i | input | 8 | Current minutes field |
| hour_i | input | 8 | Current hours field |
| batt_ok_i | input | 1 | Backup supply good |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_re_i | input | 1 | Register read strobe (clears flags at address 4) |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that the time fields are settled whenever `update_done_i` is high. They also assume that each strobe stands for one event per cycle, so a strobe held high for several cycles counts as repeated events. The stimulus draws the time fields mostly from the alarm values last written, so that full matches and single-field mismatches both occur often. It mixes clearing reads with event strobes in the same cycle, and it sends writes and reads to the read-only and unused addresses.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam logic [2:0] ADR_ALM0  = 3'd0;
  localparam logic [2:0] ADR_CTRL  = 3'd3;
  localparam logic [2:0] ADR_FLAG  = 3'd4;
  localparam logic [2:0] ADR_STAT  = 3'd5;
  // event vector layout, msb first: periodic, alarm, update-ended
  localparam int unsigned EV_N   = 3;
  localparam int unsigned EV_PER = 2;
  localparam int unsigned EV_ALM = 1;
  localparam int unsigned EV_UPD = 0;
  // byte positions
  localparam int unsigned BIT_REQ = 7;
  localparam int unsigned BIT_EV_LO = 4;
  localparam int unsigned BIT_GOOD = 7;
endpackage

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int unsigned DW = 8,
  parameter int unsigned NF = 3
) (
  input  logic [NF-1:0][DW-1:0] time_i,
  input  logic [NF-1:0][DW-1:0] alarm_i,
  input  logic                  eval_i,
  output logic                  hit_o
);
  logic [NF-1:0] eq;

  for (genvar i = 0; i < NF; i++) begin : g_field
    assign eq[i] = (time_i[i] == alarm_i[i]);
  end

  assign hit_o = eval_i & (&eq);
endmodule

// File: rtl/flag_bank.sv
module flag_bank
  import rtc_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [EV_N-1:0] set_i,
  input  logic            clr_i,
  input  logic [EV_N-1:0] en_i,
  output logic [EV_N-1:0] flags_o,
  output logic            req_o
);
  logic [EV_N-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (clr_i ? '0 : q) | set_i;  // set beats clear
  end

  assign flags_o = q;
  assign req_o   = |(q & en_i);

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> (q == '0));

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((q & $past(set_i)) == $past(set_i)));

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/reg_rd_mux.sv
module reg_rd_mux
  import rtc_irq_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3,
  parameter int unsigned NF = 3
) (
  input  logic [AW-1:0]         addr_i,
  input  logic [NF-1:0][DW-1:0] alarm_i,
  input  logic [DW-1:0]         ctrl_i,
  input  logic [EV_N-1:0]       flags_i,
  input  logic                  req_i,
  input  logic                  good_i,
  output logic [DW-1:0]         rdata_o
);
  localparam int unsigned LOW_W = DW - EV_N - 1;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NF; i++)
      if (addr_i == AW'(ADR_ALM0) + AW'(i)) rdata_o = alarm_i[i];
    if (addr_i == AW'(ADR_CTRL)) rdata_o = ctrl_i;
    if (addr_i == AW'(ADR_FLAG)) rdata_o = {req_i, flags_i, {LOW_W{1'b0}}};
    if (addr_i == AW'(ADR_STAT)) rdata_o = {good_i, {(DW-1){1'b0}}};
  end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          periodic_i,
  input  logic          update_done_i,
  input  logic [DW-1:0] sec_i,
  input  logic [DW-1:0] min_i,
  input  logic [DW-1:0] hour_i,
  input  logic          batt_ok_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_we_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          reg_re_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  localparam int unsigned NF = 3;

  logic [NF-1:0][DW-1:0] alarm_q;
  logic [NF-1:0][DW-1:0] time_v;
  logic [DW-1:0]         ctrl_q;
  logic [EV_N-1:0]       ev_set, ev_en, flags;
  logic                  hit, req, clr;

  assign time_v = {hour_i, min_i, sec_i};

  for (genvar i = 0; i < NF; i++) begin : g_alm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) alarm_q[i] <= '0;
      else if (reg_we_i && reg_addr_i == AW'(ADR_ALM0) + AW'(i))
        alarm_q[i] <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (reg_we_i && reg_addr_i == AW'(ADR_CTRL)) ctrl_q <= reg_wdata_i;
  end

  alarm_cmp #(.DW(DW), .NF(NF)) u_cmp (
    .time_i (time_v),
    .alarm_i(alarm_q),
    .eval_i (update_done_i),
    .hit_o  (hit)
  );

  assign ev_set = {periodic_i, hit, update_done_i};
  assign ev_en  = ctrl_q[BIT_EV_LO +: EV_N];
  assign clr    = reg_re_i && (reg_addr_i == AW'(ADR_FLAG));

  flag_bank u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ev_set),
    .clr_i  (clr),
    .en_i   (ev_en),
    .flags_o(flags),
    .req_o  (req)
  );

  reg_rd_mux #(.DW(DW), .AW(AW), .NF(NF)) u_rd (
    .addr_i (reg_addr_i),
    .alarm_i(alarm_q),
    .ctrl_i (ctrl_q),
    .flags_i(flags),
    .req_i  (req),
    .good_i (batt_ok_i),
    .rdata_o(reg_rdata_o)
  );

  assign irq_o = req;

  assert_alarm_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_done_i && sec_i == alarm_q[0] && min_i == alarm_q[1] && hour_i == alarm_q[2])
    |=> flags[EV_ALM]);

  assert_no_alarm_off_update_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!update_done_i && !flags[EV_ALM]) |=> !flags[EV_ALM]);

  assert_irq_needs_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctrl_q[BIT_EV_LO +: EV_N] != '0));

  assert_low_bits_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == AW'(ADR_FLAG)) |-> (reg_rdata_o[BIT_EV_LO-1:0] == '0));

  assert_ro_write_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i >= AW'(ADR_FLAG))
    |=> (ctrl_q == $past(ctrl_q) && alarm_q == $past(alarm_q)));
endmodule

// File: tb/rtc_alarm_irq_test.sv
`timescale 1ns/1ps
module rtc_alarm_irq_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       per = 0, upd = 0, batt = 1, we = 0, re = 0;
  logic [7:0] sec = 0, mn = 0, hr = 0, wdata = 0;
  logic [2:0] addr = 0;
  logic [7:0] rdata;
  logic       irq;

  // staged stimulus, applied at the next falling edge
  logic       n_per, n_upd, n_batt = 1, n_we, n_re;
  logic [7:0] n_sec = 0, n_mn = 0, n_hr = 0, n_wdata;
  logic [2:0] n_addr;

  // reference model
  logic [7:0] m_alm [3];
  logic [7:0] m_ctrl;
  logic [2:0] m_fl;  // {periodic, alarm, update}

  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  rtc_alarm_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .periodic_i(per), .update_done_i(upd),
    .sec_i(sec), .min_i(mn), .hour_i(hr), .batt_ok_i(batt),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_re_i(re),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic exp_req();
    return |(m_fl & m_ctrl[6:4]);
  endfunction

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0, 3'd1, 3'd2: return m_alm[a];
      3'd3: return m_ctrl;
      3'd4: return {exp_req(), m_fl, 4'b0};
      3'd5: return {batt, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %02h expected %02h (addr %0d)", tag, act, exp, addr);
    end
  endtask

  task automatic idle();
    n_per = 0; n_upd = 0; n_we = 0; n_re = 0; n_addr = 3'd4; n_wdata = 0;
  endtask

  task automatic go(string tag);
    logic hit;
    @(negedge clk);
    per = n_per; upd = n_upd; batt = n_batt; we = n_we; re = n_re;
    addr = n_addr; wdata = n_wdata; sec = n_sec; mn = n_mn; hr = n_hr;
    #2;
    check(tag, rdata, exp_rd(addr));
    check(tag, {7'b0, irq}, {7'b0, exp_req()});
    @(posedge clk);
    hit = upd && sec == m_alm[0] && mn == m_alm[1] && hr == m_alm[2];
    m_fl = ((re && addr == 3'd4) ? 3'b000 : m_fl) | {per, hit, upd};
    if (we && addr < 3'd3) m_alm[addr] = wdata;
    if (we && addr == 3'd3) m_ctrl = wdata;
    idle();
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, string tag);
    n_we = 1; n_addr = a; n_wdata = d; go(tag);
  endtask

  task automatic peek(logic [2:0] a, string tag);
    n_addr = a; go(tag);
  endtask

  initial begin
    #4_000_000;
    nerr++;
    $display("FAIL watchdog: run did not end");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    foreach (m_alm[i]) m_alm[i] = 0;
    m_ctrl = 0; m_fl = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state on every register
    for (int a = 0; a < 8; a++) peek(3'(a), "R1");

    // R2: write and read back alarm bytes and control
    wr(3'd0, 8'h30, "R2"); wr(3'd1, 8'h15, "R2"); wr(3'd2, 8'h09, "R2");
    wr(3'd3, 8'h70, "R2");
    for (int a = 0; a < 8; a++) peek(3'(a), "R2");

    // R10: writes to read-only and unused addresses
    wr(3'd4, 8'hFF, "R10"); wr(3'd5, 8'hFF, "R10"); wr(3'd7, 8'hA5, "R10");
    for (int a = 0; a < 8; a++) peek(3'(a), "R10");

    // R3/R4: update with the seconds field one off, then hours off
    n_sec = 8'h31; n_mn = 8'h15; n_hr = 8'h09; n_upd = 1; go("R4");
    peek(3'd4, "R3");
    n_re = 1; peek(3'd4, "R7");
    peek(3'd4, "R7");
    n_sec = 8'h30; n_hr = 8'h08; n_upd = 1; go("R4");
    n_re = 1; peek(3'd4, "R4");
    // exact match but no update strobe
    n_hr = 8'h09; go("R4");
    peek(3'd4, "R4");
    // full match with the strobe
    n_upd = 1; go("R4");
    peek(3'd4, "R4");
    // addressing flags without the read strobe keeps them
    peek(3'd4, "R7");
    n_re = 1; peek(3'd4, "R7");
    peek(3'd4, "R7");

    // R5/R6: flags set with enables off, irq follows enables
    wr(3'd3, 8'h00, "R6");
    n_per = 1; go("R5");
    peek(3'd4, "R5");
    wr(3'd3, 8'h20, "R6");
    peek(3'd4, "R6");
    wr(3'd3, 8'h40, "R6");
    peek(3'd4, "R6");

    // R8: event during the clearing read survives
    n_re = 1; n_addr = 3'd4; n_upd = 1; go("R8");
    peek(3'd4, "R8");
    n_re = 1; n_addr = 3'd4; n_per = 1; go("R8");
    peek(3'd4, "R8");

    // R9: supply status
    n_batt = 0; peek(3'd5, "R9");
    n_batt = 1; peek(3'd5, "R9");

    // random phase
    for (int k = 0; k < 600; k++) begin
      n_we    = ($urandom % 4) == 0;
      n_addr  = 3'($urandom % 8);
      n_wdata = ($urandom % 2) ? 8'($urandom % 4) : 8'($urandom);
      n_re    = ($urandom % 3) == 0;
      n_per   = ($urandom % 5) == 0;
      n_upd   = ($urandom % 3) == 0;
      n_batt  = ($urandom % 8) != 0;
      if ($urandom % 2) begin
        n_sec = m_alm[0]; n_mn = m_alm[1]; n_hr = m_alm[2];
        case ($urandom % 4)
          0: n_sec = n_sec + 8'd1;
          1: n_mn  = n_mn + 8'd1;
          2: n_hr  = n_hr + 8'd1;
          default: ;
        endcase
      end else begin
        n_sec = 8'($urandom % 4); n_mn = 8'($urandom % 4); n_hr = 8'($urandom % 4);
      end
      go("R4 R6 R7 R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule